// File: doc/BRIEF.md
# Prescaled Interval Timer with Overflow Interrupt

This block is an 8-bit up-counter driven by a divided clock. A 3-bit select sets the divider. Select 0 produces a count step every 2 clocks. Any other select value n produces a step every 32 shifted left by n clocks, so the steps range from 64 up to 4096 clocks. Counting is gated by an enable bit. When it is cleared, both the count and the position inside the current divider period are held, so counting resumes where it stopped.

Each time the count rolls over from 0xFF to 0x00, the block pulses an interrupt request for one clock. Alongside the request it presents a priority level and a vector, each taken from its own register. A sticky overflow flag records the rollover until software writes it back to zero. Software can also load the count at any time, and doing so restarts the divider period. A change of divider select waits for the current period to finish before it takes effect. Prioritisation among interrupt sources is left to the interrupt controller outside the block.

The run control is a two-state machine. `ST_HALT` means counting is frozen and `ST_RUN` means counting is active. The *arm* transition goes from `ST_HALT` to `ST_RUN` when the control byte is written with the enable bit set. The *disarm* transition goes from `ST_RUN` to `ST_HALT` when the control byte is written with the enable bit clear. Every other input keeps the present state.

Top module: `pit_timer`

## Requirements
- R1: After reset every register reads 0x00, `irq_req` is low, and `irq_level` and `irq_vector` are zero.
- R2: With select 0 and the timer enabled, the count steps by one every 2 clocks.
- R3: With select n from 1 to 7 and the timer enabled, the count steps by one every 32·2^n clocks.
- R4: Control bit 5 enables counting. While it is clear, the count and the divider phase hold, and on re-enable the interrupted period finishes with its remaining clocks.
- R5: The count is 8 bits wide and steps by exactly one. Stepping past 0xFF gives 0x00, and `irq_req` is high for exactly one clock, starting with the edge at which the count becomes 0x00.
- R6: `irq_level` equals bits 7:4 of the priority register at address 2, and `irq_vector` equals bits 6:0 of the vector register at address 3. Both registers read back all 8 bits.
- R7: A write to the count register at address 1 loads the count at that edge and restarts the divider period. The next step comes a full period later.
- R8: Control bit 7 is the overflow flag. It is set at the same edge as the request. Writing the control byte with bit 7 at 0 clears it, writing bit 7 at 1 leaves it unchanged, and a rollover in the same cycle wins over a clear.
- R9: A new divider select takes effect only at the next period boundary. The period in progress completes at its old length and no partial step occurs.
- R10: Register map: address 0 is control, laid out as {flag[7], 0, enable[5], 0, 0, select[2:0]}; address 1 is count; address 2 is priority; address 3 is vector. Reads are combinational and writes take effect at the clock edge.
- R11: A count write in the same cycle as a would-be rollover wins. The loaded value appears, and no request is raised and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_req | output | 1 | One-clock interrupt request on rollover |
| irq_level | output | 4 | Priority level presented with the request |
| irq_vector | output | 7 | Vector presented with the request |

## Verification
The bench targets the odd divider at select 0. A design that treated 0 as a power-of-two shift would step every 32 clocks instead of every 2. It checks that the divider phase survives a halt: a design that clears the phase on disable would step late after resuming. It checks that a select change in mid-period leaves the old period intact: a design that switches at once would step dozens of clocks early. It also targets the count write that lands on a rollover edge: a design that lets the increment win would show 0x00 and raise a spurious request. Random runs over many starting counts and lengths compare the final count and the number of request pulses, which catches both miscounted periods and double or missing pulses.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } pit_state_e;

    typedef enum logic [1:0] {
        RA_CTRL  = 2'd0,
        RA_COUNT = 2'd1,
        RA_PRIO  = 2'd2,
        RA_VECT  = 2'd3
    } pit_addr_e;

    localparam int BUS_W    = 8;
    localparam int EN_BIT   = 5;
    localparam int FLAG_BIT = 7;

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int SEL_W      = 3,
    parameter int BASE_SHIFT = 5,
    parameter int FAST_DIV   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] req_sel,
    output logic             tick
);
    localparam int PHASE_W = BASE_SHIFT + (1 << SEL_W) - 1;

    logic [PHASE_W-1:0] phase_q;
    logic [SEL_W-1:0]   act_sel_q;
    logic               at_end;

    // Last phase value of a period for a given select
    function automatic logic [PHASE_W-1:0] last_phase(input logic [SEL_W-1:0] s);
        logic [PHASE_W:0] span;
        if (s == '0)
            span = (PHASE_W+1)'(FAST_DIV);
        else
            span = (PHASE_W+1)'(1) << (BASE_SHIFT + int'(s));
        return PHASE_W'(span - (PHASE_W+1)'(1));
    endfunction

    assign at_end = (phase_q == last_phase(act_sel_q));
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q   <= '0;
            act_sel_q <= '0;
        end else if (restart) begin
            phase_q   <= '0;
            act_sel_q <= req_sel;
        end else if (run) begin
            if (at_end) begin
                phase_q   <= '0;
                act_sel_q <= req_sel;   // new select only at a boundary
            end else begin
                phase_q   <= phase_q + PHASE_W'(1);
            end
        end
    end

    // Phase never leaves the period of the active select
    assert_phase_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= last_phase(act_sel_q));

    // No period is shorter than two clocks
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // Holding run low freezes the phase
    assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] count_q;

    assign count = count_q;
    assign wrap  = tick && !load && (count_q == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (tick)
            count_q <= count_q + CNT_W'(1);
    end

    assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(load_val));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count_q));

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             wrap,
    output logic             run,
    output logic [SEL_W-1:0] sel,
    output logic             flag,
    output logic             irq_req
);
    pit_state_e       state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic             flag_q;
    logic             irq_q;

    // Next-state logic: arm / disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && wdata[EN_BIT])  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !wdata[EN_BIT]) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Outputs of the machine
    always_comb begin
        run     = (state_q == ST_RUN);
        sel     = sel_q;
        flag    = flag_q;
        irq_req = irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= wrap;
            if (ctrl_wr)
                sel_q <= wdata[SEL_W-1:0];
            if (wrap)
                flag_q <= 1'b1;
            else if (ctrl_wr && !wdata[FLAG_BIT])
                flag_q <= 1'b0;
        end
    end

    assert_req_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);

    assert_flag_clear_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(ctrl_wr && !wdata[FLAG_BIT]));

    assert_enable_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run == $past(wdata[EN_BIT])));

endmodule

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int LEVEL_W = 4,
    parameter int VEC_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [1:0]         addr,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [BUS_W-1:0]   ctrl_byte,
    input  logic [BUS_W-1:0]   count_byte,
    output logic [BUS_W-1:0]   rdata,
    output logic [LEVEL_W-1:0] level,
    output logic [VEC_W-1:0]   vector
);
    logic [BUS_W-1:0] prio_q;
    logic [BUS_W-1:0] vect_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            vect_q <= '0;
        end else if (wr) begin
            if (pit_addr_e'(addr) == RA_PRIO) prio_q <= wdata;
            if (pit_addr_e'(addr) == RA_VECT) vect_q <= wdata;
        end
    end

    assign level  = prio_q[BUS_W-1 -: LEVEL_W];
    assign vector = vect_q[VEC_W-1:0];

    always_comb begin
        unique case (pit_addr_e'(addr))
            RA_CTRL:  rdata = ctrl_byte;
            RA_COUNT: rdata = count_byte;
            RA_PRIO:  rdata = prio_q;
            RA_VECT:  rdata = vect_q;
            default:  rdata = '0;
        endcase
    end

    assert_prio_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pit_addr_e'(addr) == RA_PRIO) |=> level == $past(wdata[BUS_W-1 -: LEVEL_W]));

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int BASE_SHIFT = 5,
    parameter int FAST_DIV   = 2,
    parameter int LEVEL_W    = 4,
    parameter int VEC_W      = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               irq_req,
    output logic [LEVEL_W-1:0] irq_level,
    output logic [VEC_W-1:0]   irq_vector
);
    logic             ctrl_wr, cnt_wr;
    logic             run, flag, tick, wrap;
    logic [SEL_W-1:0] sel;
    logic [BUS_W-1:0] count;
    logic [BUS_W-1:0] ctrl_byte;

    assign ctrl_wr = bus_wr && (pit_addr_e'(bus_addr) == RA_CTRL);
    assign cnt_wr  = bus_wr && (pit_addr_e'(bus_addr) == RA_COUNT);

    always_comb begin
        ctrl_byte                = '0;
        ctrl_byte[SEL_W-1:0]     = sel;
        ctrl_byte[EN_BIT]        = run;
        ctrl_byte[FLAG_BIT]      = flag;
    end

    pit_ctrl #(.SEL_W(SEL_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .wrap    (wrap),
        .run     (run),
        .sel     (sel),
        .flag    (flag),
        .irq_req (irq_req)
    );

    pit_prescaler #(
        .SEL_W      (SEL_W),
        .BASE_SHIFT (BASE_SHIFT),
        .FAST_DIV   (FAST_DIV)
    ) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cnt_wr),
        .req_sel (sel),
        .tick    (tick)
    );

    pit_counter #(.CNT_W(BUS_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (cnt_wr),
        .load_val (bus_wdata),
        .count    (count),
        .wrap     (wrap)
    );

    pit_regs #(.LEVEL_W(LEVEL_W), .VEC_W(VEC_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .ctrl_byte  (ctrl_byte),
        .count_byte (count),
        .rdata      (bus_rdata),
        .level      (irq_level),
        .vector     (irq_vector)
    );

    assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(count));

    assert_req_means_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && tick && count == 8'hFF) |=> (irq_req && count == 8'h00));

    assert_no_req_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !irq_req);

endmodule

// File: tb/pit_timer_tb_top.sv
module pit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic [3:0] irq_level;
    logic [6:0] irq_vector;

    int checks = 0;
    int failures = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    always @(negedge clk) if (rst_n && irq_req) pulses++;

    function automatic int period_of(input int s);
        return (s == 0) ? 2 : (32 << s);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a; #1;
        v = int'(bus_rdata);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic start(input int s, input int c0);
        wr(2'd0, 8'(s));
        wr(2'd1, 8'(c0));
        wr(2'd0, 8'(8'h20 | s));
        pulses = 0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_500_000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 0);
        rd(2'd1, v); chk("R1 count", v, 0);
        rd(2'd2, v); chk("R1 prio", v, 0);
        rd(2'd3, v); chk("R1 vect", v, 0);
        chk("R1 irq", int'(irq_req), 0);
        chk("R1 level", int'(irq_level), 0);
        chk("R1 vector", int'(irq_vector), 0);

        // R2 select 0: one step per 2 clocks
        start(0, 0); step(20);
        rd(2'd1, v); chk("R2 count after 20", v, 10);

        // R4 halt holds count and phase
        start(0, 0); step(6);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R4 count at halt", v, 3);
        step(50);
        rd(2'd1, v); chk("R4 frozen", v, 3);
        rd(2'd0, v); chk("R4 ctrl halted", v, 0);
        wr(2'd0, 8'h20);
        rd(2'd1, v); chk("R4 resume edge", v, 3);
        step(1);
        rd(2'd1, v); chk("R4 remaining phase", v, 4);

        // R5 / R8 rollover
        start(0, 8'hFE); step(3);
        rd(2'd1, v); chk("R5 before wrap", v, 8'hFF);
        chk("R5 no early irq", int'(irq_req), 0);
        step(1);
        rd(2'd1, v); chk("R5 wrapped", v, 0);
        chk("R5 irq high", int'(irq_req), 1);
        rd(2'd0, v); chk("R8 flag set", v, 8'hA0);
        step(1);
        chk("R5 irq one clock", int'(irq_req), 0);
        wr(2'd0, 8'hA0);
        rd(2'd0, v); chk("R8 write one keeps", v, 8'hA0);
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R8 write zero clears", v, 8'h20);

        // R11 load wins over rollover
        start(0, 8'hFF); step(1);
        wr(2'd1, 8'h10);
        rd(2'd1, v); chk("R11 loaded", v, 8'h10);
        chk("R11 no irq", int'(irq_req), 0);
        step(1);
        chk("R11 no irq later", int'(irq_req), 0);
        rd(2'd0, v); chk("R11 no flag", v, 8'h20);
        chk("R11 pulses", pulses, 0);

        // R7 count write restarts period (select 1 = 64 clocks)
        start(1, 0); step(100);
        rd(2'd1, v); chk("R7 pre-load", v, 1);
        wr(2'd1, 8'h40);
        step(63);
        rd(2'd1, v); chk("R7 full period pending", v, 8'h40);
        step(1);
        rd(2'd1, v); chk("R7 step after full period", v, 8'h41);

        // R9 select change waits for boundary
        start(1, 0); step(9);
        wr(2'd0, 8'h20);
        rd(2'd0, v); chk("R10 ctrl reads new select", v, 8'h20);
        step(53);
        rd(2'd1, v); chk("R9 old period intact", v, 0);
        step(1);
        rd(2'd1, v); chk("R9 old period end", v, 1);
        step(2);
        rd(2'd1, v); chk("R9 new period", v, 2);

        // R3 longest and a middle select
        start(7, 0); step(4095);
        rd(2'd1, v); chk("R3 sel7 not yet", v, 0);
        step(1);
        rd(2'd1, v); chk("R3 sel7 step", v, 1);
        start(2, 5); step(128 * 3);
        rd(2'd1, v); chk("R3 sel2", v, 8);

        // R6 level and vector
        wr(2'd2, 8'hB5);
        wr(2'd3, 8'hFF);
        chk("R6 level", int'(irq_level), 4'hB);
        chk("R6 vector", int'(irq_vector), 7'h7F);
        rd(2'd2, v); chk("R6 prio readback", v, 8'hB5);
        rd(2'd3, v); chk("R6 vect readback", v, 8'hFF);
        wr(2'd3, 8'h13);
        chk("R6 vector 13", int'(irq_vector), 7'h13);

        // Random runs: R2 R3 R5
        for (int it = 0; it < 24; it++) begin
            int s, c0, n, total;
            s  = int'($urandom_range(0, 3));
            c0 = int'($urandom_range(0, 255));
            n  = int'($urandom_range(1, 700));
            start(s, c0);
            step(n);
            wr(2'd0, 8'(s));
            step(2);
            total = c0 + (n + 1) / period_of(s);
            rd(2'd1, v); chk("R3 random count", v, total & 255);
            chk("R5 random pulses", pulses, total >> 8);
        end

        summary();
    end
endmodule